// File: doc/BRIEF.md
# Multibit Trie Longest-Prefix Lookup Engine

This block resolves a 32-bit destination address to a next-hop identifier by walking a trie held in an on-chip node memory. The walk takes the address a fixed number of bits (the stride) at a time, starting with the most significant bits. Each step reads one node word. The word carries a flag that says whether the node ends a stored prefix, the next hop for that prefix, and one child index for each value the stride bits can take. The engine keeps the next hop of the deepest flagged node it has passed. When it meets an empty child, or when the address bits run out, it returns that next hop. If no flagged node lay on the path, it reports a miss.

The table is built outside the block. Prefixes whose length is not a multiple of the stride are written as several expanded entries at the next stride boundary. Software or the testbench loads node words through a plain write port. A lookup begins with a start pulse while the engine is ready. The engine then issues one node read per clock and holds a single lookup at a time. The result comes back as a one-cycle valid pulse, together with a miss flag.

Top module: `lpm_trie_lookup`

## Requirements
- R1: After reset, `ready` is 1 and `res_valid` is 0.
- R2: Node word layout: the top bit is the prefix-end flag, the NH_W bits below it hold the next hop, and child j (j = 0 .. 2^STRIDE-1) sits at bits [j*IDX_W +: IDX_W]. The root is node 0. At depth d the child chosen is the address field of STRIDE bits that starts d*STRIDE bits below the most significant bit.
- R3: When more than one flagged node lies on the path, the result is the next hop of the deepest one.
- R4: A child index of 0 means no child. The walk stops at the node that holds such an entry and does not fetch node 0.
- R5: When no flagged node lies on the path, the result has `res_miss` = 1 and `res_nh` = 0.
- R6: A walk never goes deeper than ADDR_W/STRIDE. The node at the final depth is examined for its flag, and the engine then finishes without reading another node. For the default parameters that is 17 node reads.
- R7: `res_valid` is a single-cycle pulse. It rises exactly N clock edges after the edge that accepted `start`, where N is the number of nodes read. `ready` is 1 in that cycle.
- R8: `ready` is 0 while a lookup is in progress, and a `start` given then is ignored. It produces no second result and does not change the current result.
- R9: A node word written through the init port while the engine is idle is used by every later lookup.
- R10: A flagged root acts as the default route and is returned for any address with no longer match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a lookup; taken only while ready is high |
| lookup_addr | input | ADDR_W | Destination address, sampled with start |
| ready | output | 1 | Engine idle and able to accept start |
| res_valid | output | 1 | One-cycle pulse marking a finished lookup |
| res_nh | output | NH_W | Next hop of the longest match (0 on a miss) |
| res_miss | output | 1 | No prefix matched the address |
| init_we | input | 1 | Node memory write enable |
| init_idx | input | IDX_W | Node index to write |
| init_word | input | 1+NH_W+2^STRIDE*IDX_W | Node word to store |

## Verification
The checker assumes that the node memory is written only while the engine is idle. It also assumes that the table is acyclic and that every child index points at a word that has been written. The bench clears every node word before it builds its tables, and it issues init writes only between lookups, while ready is high. The only start given during a walk is the one the busy-ignore scenario sends on purpose, and that is the case the assertions expect to have no effect.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [0:0] {
    WALK_IDLE = 1'b0,
    WALK_STEP = 1'b1
  } walk_state_t;
endpackage

// File: rtl/trie_node_ram.sv
module trie_node_ram #(
  parameter int WORD_W = 41,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_word
);
  localparam int DEPTH = 1 << IDX_W;

  logic [WORD_W-1:0] store [DEPTH];

  // One write and one registered read per cycle.
  always_ff @(posedge clk) begin
    if (wr_en) store[wr_idx] <= wr_word;
    if (rd_en) rd_word <= store[rd_idx];
  end
endmodule

// File: rtl/trie_node_decode.sv
module trie_node_decode #(
  parameter int STRIDE = 2,
  parameter int NH_W   = 8,
  parameter int IDX_W  = 8
) (
  input  logic [1+NH_W+(1<<STRIDE)*IDX_W-1:0] node_word,
  input  logic [STRIDE-1:0]                    slice,
  output logic                                 node_marked,
  output logic [NH_W-1:0]                      node_nh,
  output logic [IDX_W-1:0]                     child_idx
);
  localparam int FANOUT = 1 << STRIDE;
  localparam int WORD_W = 1 + NH_W + FANOUT * IDX_W;

  logic [IDX_W-1:0] kids [FANOUT];

  for (genvar j = 0; j < FANOUT; j++) begin : g_kid
    assign kids[j] = node_word[j*IDX_W +: IDX_W];
  end

  assign node_marked = node_word[WORD_W-1];
  assign node_nh     = node_word[WORD_W-2 -: NH_W];
  assign child_idx   = kids[slice];
endmodule

// File: rtl/trie_walk_ctrl.sv
module trie_walk_ctrl
  import lpm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int STRIDE = 2,
  parameter int NH_W   = 8,
  parameter int IDX_W  = 8,
  localparam int LEVELS = ADDR_W / STRIDE,
  localparam int LVL_W  = $clog2(LEVELS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] lookup_addr,
  input  logic              node_marked,
  input  logic [NH_W-1:0]   node_nh,
  input  logic [IDX_W-1:0]  child_idx,
  output logic [STRIDE-1:0] slice,
  output logic              rd_en,
  output logic [IDX_W-1:0]  rd_idx,
  output logic              ready,
  output logic              walking,
  output logic [LVL_W-1:0]  walk_lvl,
  output logic              res_valid,
  output logic [NH_W-1:0]   res_nh,
  output logic              res_miss
);
  localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LEVELS);

  // Stride field at a given depth, taken from the most significant end.
  function automatic logic [STRIDE-1:0] addr_slice(
    input logic [ADDR_W-1:0] a,
    input logic [LVL_W-1:0]  l
  );
    logic [ADDR_W-1:0] sh;
    sh = a << (int'(l) * STRIDE);
    return sh[ADDR_W-1 -: STRIDE];
  endfunction

  walk_state_t       state;
  logic [ADDR_W-1:0] key;
  logic [LVL_W-1:0]  lvl;
  logic [NH_W-1:0]   best_nh;
  logic              best_seen;

  logic              accept, descend, finish, at_last;
  logic              eff_seen;
  logic [NH_W-1:0]   eff_nh;

  assign ready    = (state == WALK_IDLE);
  assign walking  = (state == WALK_STEP);
  assign walk_lvl = lvl;
  assign slice    = addr_slice(key, lvl);
  assign at_last  = (lvl == LAST_LVL);

  assign eff_seen = best_seen | node_marked;
  assign eff_nh   = node_marked ? node_nh : best_nh;

  assign accept  = ready && start;
  assign descend = walking && !at_last && (child_idx != '0);
  assign finish  = walking && !descend;

  assign rd_en  = accept || descend;
  assign rd_idx = accept ? '0 : child_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= WALK_IDLE;
      key       <= '0;
      lvl       <= '0;
      best_nh   <= '0;
      best_seen <= 1'b0;
      res_valid <= 1'b0;
      res_nh    <= '0;
      res_miss  <= 1'b0;
    end else begin
      res_valid <= finish;
      if (accept) begin
        state     <= WALK_STEP;
        key       <= lookup_addr;
        lvl       <= '0;
        best_nh   <= '0;
        best_seen <= 1'b0;
      end
      if (walking) begin
        best_seen <= eff_seen;
        best_nh   <= eff_nh;
        if (descend) lvl <= lvl + 1'b1;
        if (finish) begin
          state    <= WALK_IDLE;
          res_nh   <= eff_seen ? eff_nh : '0;
          res_miss <= !eff_seen;
        end
      end
    end
  end
endmodule

// File: rtl/lpm_trie_lookup.sv
module lpm_trie_lookup #(
  parameter int ADDR_W = 32,
  parameter int STRIDE = 2,
  parameter int NH_W   = 8,
  parameter int IDX_W  = 8,
  localparam int FANOUT = 1 << STRIDE,
  localparam int WORD_W = 1 + NH_W + FANOUT * IDX_W,
  localparam int LEVELS = ADDR_W / STRIDE,
  localparam int LVL_W  = $clog2(LEVELS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] lookup_addr,
  output logic              ready,
  output logic              res_valid,
  output logic [NH_W-1:0]   res_nh,
  output logic              res_miss,
  input  logic              init_we,
  input  logic [IDX_W-1:0]  init_idx,
  input  logic [WORD_W-1:0] init_word
);
  logic              rd_en;
  logic [IDX_W-1:0]  rd_idx;
  logic [WORD_W-1:0] rd_word;
  logic              node_marked;
  logic [NH_W-1:0]   node_nh;
  logic [IDX_W-1:0]  child_idx;
  logic [STRIDE-1:0] slice;
  logic              walking;
  logic [LVL_W-1:0]  walk_lvl;

  trie_node_ram #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_ram (
    .clk     (clk),
    .wr_en   (init_we),
    .wr_idx  (init_idx),
    .wr_word (init_word),
    .rd_en   (rd_en),
    .rd_idx  (rd_idx),
    .rd_word (rd_word)
  );

  trie_node_decode #(.STRIDE(STRIDE), .NH_W(NH_W), .IDX_W(IDX_W)) u_dec (
    .node_word   (rd_word),
    .slice       (slice),
    .node_marked (node_marked),
    .node_nh     (node_nh),
    .child_idx   (child_idx)
  );

  trie_walk_ctrl #(.ADDR_W(ADDR_W), .STRIDE(STRIDE), .NH_W(NH_W), .IDX_W(IDX_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .lookup_addr (lookup_addr),
    .node_marked (node_marked),
    .node_nh     (node_nh),
    .child_idx   (child_idx),
    .slice       (slice),
    .rd_en       (rd_en),
    .rd_idx      (rd_idx),
    .ready       (ready),
    .walking     (walking),
    .walk_lvl    (walk_lvl),
    .res_valid   (res_valid),
    .res_nh      (res_nh),
    .res_miss    (res_miss)
  );
endmodule

// File: rtl/lpm_trie_lookup_chk.sv
module lpm_trie_lookup_chk #(
  parameter int ADDR_W = 32,
  parameter int STRIDE = 2,
  parameter int NH_W   = 8,
  parameter int IDX_W  = 8,
  localparam int LEVELS = ADDR_W / STRIDE,
  localparam int LVL_W  = $clog2(LEVELS + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             ready,
  input logic             res_valid,
  input logic [NH_W-1:0]  res_nh,
  input logic             res_miss,
  input logic             rd_en,
  input logic [IDX_W-1:0] rd_idx,
  input logic             walking,
  input logic [LVL_W-1:0] walk_lvl,
  input logic             init_we
);
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ready);

  a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && start) |=> !ready);

  a_r5_miss_zero_nh: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_miss) |-> (res_nh == '0));

  a_r4_no_null_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && walking) |-> (rd_idx != '0));

  a_r6_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
    walking |-> (int'(walk_lvl) <= LEVELS));

  a_r9_init_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    init_we |-> ready);
endmodule

bind lpm_trie_lookup lpm_trie_lookup_chk #(
  .ADDR_W(ADDR_W), .STRIDE(STRIDE), .NH_W(NH_W), .IDX_W(IDX_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .ready     (ready),
  .res_valid (res_valid),
  .res_nh    (res_nh),
  .res_miss  (res_miss),
  .rd_en     (rd_en),
  .rd_idx    (rd_idx),
  .walking   (walking),
  .walk_lvl  (walk_lvl),
  .init_we   (init_we)
);

// File: tb/sim_lpm_trie_lookup.sv
module sim_lpm_trie_lookup;
  localparam int ADDR_W = 32;
  localparam int STRIDE = 2;
  localparam int NH_W   = 8;
  localparam int IDX_W  = 8;
  localparam int WORD_W = 1 + NH_W + 4 * IDX_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [ADDR_W-1:0] lookup_addr = '0;
  logic              ready, res_valid, res_miss;
  logic [NH_W-1:0]   res_nh;
  logic              init_we = 1'b0;
  logic [IDX_W-1:0]  init_idx = '0;
  logic [WORD_W-1:0] init_word = '0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  lpm_trie_lookup #(.ADDR_W(ADDR_W), .STRIDE(STRIDE), .NH_W(NH_W), .IDX_W(IDX_W)) u0 (
    .clk, .rst_n, .start, .lookup_addr, .ready, .res_valid, .res_nh, .res_miss,
    .init_we, .init_idx, .init_word
  );

  // Node word: {flag, next hop, child3, child2, child1, child0}
  function automatic logic [WORD_W-1:0] mk(input bit f, input logic [NH_W-1:0] nh,
      input logic [IDX_W-1:0] c3, c2, c1, c0);
    return {f, nh, c3, c2, c1, c0};
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, what, act, act, exp, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [WORD_W-1:0] w);
    @(negedge clk);
    init_we = 1'b1; init_idx = IDX_W'(idx); init_word = w;
    @(negedge clk);
    init_we = 1'b0;
  endtask

  task automatic lookup(input string req, input logic [ADDR_W-1:0] a,
      input int exp_nh, input bit exp_miss, input int exp_reads);
    int n;
    @(negedge clk);
    chk(req, "ready before start", int'(ready), 1);
    start = 1'b1; lookup_addr = a;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!res_valid && n < 40) begin
      @(negedge clk);
      n++;
    end
    chk(req, "node reads (latency)", n, exp_reads);
    chk(req, "next hop", int'(res_nh), exp_nh);
    chk(req, "miss flag", int'(res_miss), int'(exp_miss));
    @(negedge clk);
    chk(req, "valid is a pulse", int'(res_valid), 0);
  endtask

  task automatic t_reset;
    chk("R1", "ready after reset", int'(ready), 1);
    chk("R1", "res_valid after reset", int'(res_valid), 0);
  endtask

  task automatic t_build;
    for (int i = 0; i < (1 << IDX_W); i++) wr(i, '0);
    wr(0, mk(0, 0, 4, 1, 0, 0));
    wr(1, mk(1, 8'h11, 2, 0, 0, 0));
    wr(2, mk(0, 0, 0, 0, 3, 3));
    wr(3, mk(1, 8'h22, 0, 0, 0, 0));
    for (int k = 4; k < 19; k++)
      wr(k, mk(k == 10, (k == 10) ? 8'h33 : 8'h00, IDX_W'(k + 1), 0, 0, 0));
    wr(19, mk(1, 8'h7E, 0, 0, 0, 0));
  endtask

  task automatic t_paths;
    lookup("R2", 32'hB000_0000, 8'h22, 0, 4);  // 10 11 00 -> expanded entry
    lookup("R3", 32'hB400_0000, 8'h22, 0, 4);  // 10 11 01 -> second expansion
    lookup("R4", 32'hB800_0000, 8'h11, 0, 3);  // stops at empty child 10
    lookup("R5", 32'h4000_0000, 0, 1, 1);      // root child 01 empty
    lookup("R5", 32'hFC00_0000, 0, 1, 4);      // unflagged path
  endtask

  task automatic t_depth;
    lookup("R6", 32'hFFFF_FFFF, 8'h7E, 0, 17);
    lookup("R6", 32'hFFFF_FFFE, 8'h33, 0, 16);
    lookup("R3", 32'hFFFF_0000, 8'h33, 0, 9);
  endtask

  task automatic t_busy;
    int seen;
    @(negedge clk);
    start = 1'b1; lookup_addr = 32'hFFFF_FFFF;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8", "ready during walk", int'(ready), 0);
    start = 1'b1; lookup_addr = 32'h4000_0000;
    @(negedge clk);
    start = 1'b0;
    seen = 0;
    for (int c = 0; c < 40; c++) begin
      if (res_valid) begin
        seen++;
        chk("R8", "next hop of first lookup", int'(res_nh), 8'h7E);
        chk("R8", "miss of first lookup", int'(res_miss), 0);
      end
      @(negedge clk);
    end
    chk("R8", "result count", seen, 1);
  endtask

  task automatic t_update;
    wr(0, mk(1, 8'h05, 4, 1, 0, 0));
    lookup("R10", 32'h4000_0000, 8'h05, 0, 1);
    lookup("R10", 32'hFC00_0000, 8'h05, 0, 4);
    lookup("R3", 32'hB800_0000, 8'h11, 0, 3);
    wr(3, mk(1, 8'h44, 0, 0, 0, 0));
    lookup("R9", 32'hB000_0000, 8'h44, 0, 4);
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_build();
    t_paths();
    t_depth();
    t_busy();
    t_update();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule